// File: doc/BRIEF.md
# Cascadable Active-Low Priority Encoder (16-line chain)

This block turns a vector of active-low request lines into the binary index of the highest-numbered request that is active. It is built from two identical 8-line encoder slices chained through an enable-in / enable-out link. The upper slice serves lines 15..8. The lower slice serves lines 7..0 and is enabled only when the upper slice is enabled and sees no request. A small control stage combines the two slices. The upper slice's group flag becomes the most significant code bit, and the two slices' 3-bit codes are ANDed into the low bits. Both group flags are ANDed into a single active-low priority flag.

Every output is active low. The code is the bitwise inverse of the winning line index, with binary weights 8-4-2-1. A line-0 request and "no request" therefore both give an all-ones code, and only the priority flag separates them. The chain's own enable output is low only when the chain is enabled and idle, so a further stage can hang off it.

The combinational encode can glitch while inputs change. By default an output register stage captures the code, flag and enable output on each rising clock edge. A synchronous active-high reset drives all outputs to their idle high level.

Top module: `prio_enc_chain16`

## Requirements
- R1: Request lines are active low; with the chain enabled and a winning line k, the code output equals the bitwise inverse of k (bit 3 weight 8, bit 0 weight 1).
- R2: When several lines are low, only the highest-numbered low line is encoded; line 15 low gives code 0000 whatever the other lines are.
- R3: While the enable input is high, the code, priority flag and enable output are all high regardless of the request lines.
- R4: With the enable input low and all sixteen lines high, the code is 1111, the priority flag is high and the enable output is low.
- R5: With the enable input low and at least one line low, the priority flag is low and the enable output is high.
- R6: With the enable input low and only line 0 low, the code is 1111 and the priority flag is low.
- R7: Any low line among 15..8 sets code bit 3 low and fully masks lines 7..0; the lower slice encodes only when lines 15..8 are all high, and then code bit 3 is high.
- R8: Outputs change one clock after the inputs they reflect; a synchronous active-high reset sets code, flag and enable output high on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register stage |
| rst | input | 1 | Synchronous active-high reset; forces all outputs high |
| dataN | input | 16 | Active-low request lines, bit 15 highest priority |
| enN | input | 1 | Active-low chain enable |
| codeN | output | 4 | Active-low index of the winning line |
| flagN | output | 1 | Active-low priority flag: low when any line wins |
| enOutN | output | 1 | Active-low enable output: low when enabled and idle |

## Verification
The assertions relate each registered output to the request lines and enable of the previous cycle. They therefore assume the inputs are stable across each rising edge and that reset is released on an edge. The bench holds this by changing inputs only on falling edges and sampling outputs one full cycle later, on the following falling edge. The stimulus covers all 256 lower-slice patterns under both enable levels, directed cascade cases, and a large random mix of dense and sparse 16-bit patterns.

// File: rtl/prio_enc_pkg.sv
package prio_enc_pkg;
  // Strobes from the cascade control to the datapath.
  typedef struct packed {
    logic loEnN;   // enable for the lower slice
    logic msbN;    // most significant code bit
    logic flagN;   // combined priority flag
    logic eoN;     // chain enable output
  } cascade_strobes_t;
endpackage

// File: rtl/prio_enc_slice.sv
module prio_enc_slice #(
  parameter int LINES  = 8,
  parameter int CODE_W = $clog2(LINES)
) (
  input  logic [LINES-1:0]  lineN,
  input  logic              enN,
  output logic [CODE_W-1:0] codeN,
  output logic              groupN,
  output logic              enOutN
);
  logic              hit;
  logic [CODE_W-1:0] idx;

  // Ascending scan: the last low line seen is the highest one.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < LINES; i++) begin
      if (!lineN[i]) begin
        hit = 1'b1;
        idx = CODE_W'(i);
      end
    end
  end

  always_comb begin
    if (enN) begin
      codeN  = '1;
      groupN = 1'b1;
      enOutN = 1'b1;
    end else begin
      codeN  = ~idx;
      groupN = ~hit;
      enOutN = hit;
    end
  end
endmodule

// File: rtl/prio_enc_ctrl.sv
module prio_enc_ctrl
  import prio_enc_pkg::*;
(
  input  logic             hiGsN,
  input  logic             hiEoN,
  input  logic             loGsN,
  input  logic             loEoN,
  output cascade_strobes_t strobes
);
  always_comb begin
    strobes.loEnN = hiEoN;           // lower slice runs only when upper is idle
    strobes.msbN  = hiGsN;
    strobes.flagN = hiGsN & loGsN;
    strobes.eoN   = loEoN;
  end
endmodule

// File: rtl/prio_enc_datapath.sv
module prio_enc_datapath
  import prio_enc_pkg::*;
#(
  parameter int SLICE_LINES = 8,
  parameter bit REG_OUT     = 1'b1,
  localparam int TOTAL      = 2 * SLICE_LINES,
  localparam int SLICE_CW   = $clog2(SLICE_LINES),
  localparam int CW         = SLICE_CW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TOTAL-1:0] dataN,
  input  logic             enN,
  input  cascade_strobes_t strobes,
  output logic             hiGsN,
  output logic             hiEoN,
  output logic             loGsN,
  output logic             loEoN,
  output logic [CW-1:0]    codeN,
  output logic             flagN,
  output logic             enOutN
);
  logic [1:0][SLICE_CW-1:0] sliceCode;
  logic [1:0]               sliceGs;
  logic [1:0]               sliceEo;
  logic [1:0]               sliceEn;

  assign sliceEn = {enN, strobes.loEnN};

  for (genvar u = 0; u < 2; u++) begin : g_slice
    prio_enc_slice #(.LINES(SLICE_LINES)) slice_i (
      .lineN  (dataN[u*SLICE_LINES +: SLICE_LINES]),
      .enN    (sliceEn[u]),
      .codeN  (sliceCode[u]),
      .groupN (sliceGs[u]),
      .enOutN (sliceEo[u])
    );
  end

  assign hiGsN = sliceGs[1];
  assign hiEoN = sliceEo[1];
  assign loGsN = sliceGs[0];
  assign loEoN = sliceEo[0];

  logic [CW-1:0] nxtCode;
  assign nxtCode = {strobes.msbN, sliceCode[1] & sliceCode[0]};

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        codeN  <= '1;
        flagN  <= 1'b1;
        enOutN <= 1'b1;
      end else begin
        codeN  <= nxtCode;
        flagN  <= strobes.flagN;
        enOutN <= strobes.eoN;
      end
    end
  end else begin : g_comb
    assign codeN  = nxtCode;
    assign flagN  = strobes.flagN;
    assign enOutN = strobes.eoN;
  end
endmodule

// File: rtl/prio_enc_chain16.sv
module prio_enc_chain16
  import prio_enc_pkg::*;
#(
  parameter int SLICE_LINES = 8,
  parameter bit REG_OUT     = 1'b1,
  localparam int TOTAL      = 2 * SLICE_LINES,
  localparam int CW         = $clog2(TOTAL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TOTAL-1:0] dataN,
  input  logic             enN,
  output logic [CW-1:0]    codeN,
  output logic             flagN,
  output logic             enOutN
);
  cascade_strobes_t strobes;
  logic hiGsN, hiEoN, loGsN, loEoN;

  prio_enc_ctrl ctrl_i (
    .hiGsN   (hiGsN),
    .hiEoN   (hiEoN),
    .loGsN   (loGsN),
    .loEoN   (loEoN),
    .strobes (strobes)
  );

  prio_enc_datapath #(.SLICE_LINES(SLICE_LINES), .REG_OUT(REG_OUT)) dp_i (
    .clk     (clk),
    .rst     (rst),
    .dataN   (dataN),
    .enN     (enN),
    .strobes (strobes),
    .hiGsN   (hiGsN),
    .hiEoN   (hiEoN),
    .loGsN   (loGsN),
    .loEoN   (loEoN),
    .codeN   (codeN),
    .flagN   (flagN),
    .enOutN  (enOutN)
  );
endmodule

// File: rtl/prio_enc_chain16_chk.sv
module prio_enc_chain16_chk #(
  parameter int LINES   = 16,
  parameter bit REG_OUT = 1'b1,
  localparam int CW     = $clog2(LINES),
  localparam int HALF   = LINES / 2
) (
  input logic             clk,
  input logic             rst,
  input logic [LINES-1:0] dataN,
  input logic             enN,
  input logic [CW-1:0]    codeN,
  input logic             flagN,
  input logic             enOutN
);
  if (REG_OUT) begin : g_seq
    // R3
    disabled_idle_chk: assert property (@(posedge clk) disable iff (rst)
      enN |=> (codeN == '1 && flagN && enOutN));
    // R4
    idle_chain_chk: assert property (@(posedge clk) disable iff (rst)
      (!enN && (&dataN)) |=> (codeN == '1 && flagN && !enOutN));
    // R5
    active_flags_chk: assert property (@(posedge clk) disable iff (rst)
      (!enN && !(&dataN)) |=> (!flagN && enOutN));
    // R2
    top_line_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (!enN && !dataN[LINES-1]) |=> (codeN == '0));
    // R6
    line0_only_chk: assert property (@(posedge clk) disable iff (rst)
      (!enN && dataN == {{(LINES-1){1'b1}}, 1'b0}) |=> (codeN == '1 && !flagN));
    // R7
    upper_masks_chk: assert property (@(posedge clk) disable iff (rst)
      (!enN && !(&dataN[LINES-1:HALF])) |=> !codeN[CW-1]);
    // R7
    lower_msb_chk: assert property (@(posedge clk) disable iff (rst)
      (!enN && (&dataN[LINES-1:HALF]) && !(&dataN[HALF-1:0])) |=> codeN[CW-1]);
    // R8
    reset_idle_chk: assert property (@(posedge clk)
      rst |=> (codeN == '1 && flagN && enOutN));
  end
endmodule

bind prio_enc_chain16 prio_enc_chain16_chk #(.LINES(TOTAL), .REG_OUT(REG_OUT)) chk_i (
  .clk    (clk),
  .rst    (rst),
  .dataN  (dataN),
  .enN    (enN),
  .codeN  (codeN),
  .flagN  (flagN),
  .enOutN (enOutN)
);

// File: tb/prio_enc_chain16_test.sv
module prio_enc_chain16_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] dataN;
  logic        enN;
  logic [3:0]  codeN;
  logic        flagN;
  logic        enOutN;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  prio_enc_chain16 uut (
    .clk(clk), .rst(rst), .dataN(dataN), .enN(enN),
    .codeN(codeN), .flagN(flagN), .enOutN(enOutN)
  );

  // Reference: {code[3:0], flag, enOut}
  function automatic logic [5:0] model(input logic [15:0] d, input logic e);
    logic [3:0] idx;
    logic       hit;
    idx = 4'd0;
    hit = 1'b0;
    if (e) return 6'b111111;
    for (int i = 0; i < 16; i++) begin
      if (!d[i]) begin
        idx = 4'(i);
        hit = 1'b1;
      end
    end
    if (!hit) return {4'hF, 1'b1, 1'b0};
    return {~idx, 1'b0, 1'b1};
  endfunction

  task automatic check(input string req, input logic [5:0] exp);
    logic [5:0] act;
    act = {codeN, flagN, enOutN};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: dataN=%h enN=%b got code/flag/eo=%b expected %b",
               req, dataN, enN, act, exp);
    end
  endtask

  // Drive on a falling edge, sample one cycle later on the next falling edge.
  task automatic apply(input logic [15:0] d, input logic e, input string req);
    @(negedge clk);
    dataN = d;
    enN   = e;
    @(negedge clk);
    check(req, model(d, e));
  endtask

  task automatic test_reset;
    rst = 1'b1; dataN = 16'h0000; enN = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R8 reset idle", 6'b111111);
    rst = 1'b0;
  endtask

  task automatic test_disabled;
    for (int p = 0; p < 256; p++)
      apply({8'(p), 8'(p ^ 8'h5A)}, 1'b1, "R3 disabled");
    apply(16'h0000, 1'b1, "R3 all lines low, disabled");
  endtask

  task automatic test_lower_exhaustive;
    for (int p = 0; p < 256; p++)
      apply({8'hFF, 8'(p)}, 1'b0, "R1 R2 R7 lower slice exhaustive");
  endtask

  task automatic test_directed;
    apply(16'hFFFF, 1'b0, "R4 enabled idle");
    check("R4 idle code 1111 eo low", {4'hF, 1'b1, 1'b0});
    apply(16'hFFFE, 1'b0, "R6 only line 0");
    check("R6 code 1111 flag low", {4'hF, 1'b0, 1'b1});
    apply(16'h7FFF, 1'b0, "R2 line 15 alone");
    apply(16'h0000, 1'b0, "R2 all low");
    check("R2 all low gives 0000", {4'h0, 1'b0, 1'b1});
    apply(16'hFEFF, 1'b0, "R7 line 8 only");
    check("R7 line 8 code 0111", {4'h7, 1'b0, 1'b1});
    apply(16'hFE00, 1'b0, "R7 upper masks lower");
    check("R7 line 8 over lower", {4'h7, 1'b0, 1'b1});
    apply(16'hFF7F, 1'b0, "R7 line 7 msb high");
    check("R7 line 7 code 1000", {4'h8, 1'b0, 1'b1});
    apply(16'hAAAA, 1'b0, "R5 pattern");
    check("R5 flag low eo high", {4'h1, 1'b0, 1'b1});
    for (int k = 0; k < 16; k++)
      apply(~(16'd1 << k), 1'b0, "R1 single line");
  endtask

  task automatic test_random;
    logic [15:0] d;
    for (int n = 0; n < 20000; n++) begin
      if (n % 2 == 0) d = 16'($urandom);
      else d = 16'($urandom) | 16'($urandom) | 16'($urandom);
      apply(d, ($urandom % 8) == 0, "R5 R7 random 16-line");
    end
  endtask

  task automatic test_reset_midstream;
    @(negedge clk);
    dataN = 16'h1234; enN = 1'b0; rst = 1'b1;
    @(negedge clk);
    check("R8 sync reset overrides active input", 6'b111111);
    rst = 1'b0;
    @(negedge clk);
    check("R8 one cycle latency after reset", model(16'h1234, 1'b0));
  endtask

  initial begin
    test_reset;
    test_disabled;
    test_lower_exhaustive;
    test_directed;
    test_random;
    test_reset_midstream;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule